// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block is the interrupt section of a memory-mapped serial port. It keeps an 11-bit raw interrupt status word and an 11-bit enable mask, and it turns their AND into six interrupt request lines: one combined line and five per-source lines. Status bits are set by events from the surrounding port logic: a write to the data register, the receive FIFO fill level reaching its trigger level, receive-timeout and error pulses, and changes on the four modem-status lines.

Software reaches the block through a 32-bit word-addressed register port. The write strobe is a one-cycle pulse. Read data is combinational from the current state. The port gives access to the mask, to the raw and masked status views, and to a write-one-to-clear register. Storage for the FIFO and the shifter lies outside the block. The FIFO count and its trigger level arrive as plain inputs.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Reset clears the status word, the mask and all six interrupt outputs to zero.
- R2: A write to the data register (offset 0) sets status bit 5 (transmit) on that clock edge.
- R3: Status bit 4 (receive) is set on the edge where `rx_count` changes to a value equal to `rx_trigger`. A read of offset 0 while `rx_count` equals `rx_trigger` clears it. A read at any other count leaves it unchanged.
- R4: When `modem_lines` differs from its value one cycle earlier, status bits 3..0 are replaced by `modem_lines`. The line order is {DSR, DCD, CTS, RI}, so DSR maps to bit 3 and RI to bit 0.
- R5: Each `err_evt` bit, in the order {overrun, break, parity, framing}, sets status bits 10..7 in turn. `rto_evt` sets bit 6.
- R6: A write to the clear register (offset 4) clears every status bit whose data bit is 1. An event that sets a bit in the same cycle wins over the clear.
- R7: Offset 2 reads the raw status and offset 3 reads status AND mask. Writes to offsets 2 and 3 change nothing.
- R8: Offset 1 is the mask register. It is read and written on data bits 10..0, and the upper data bits are dropped.
- R9: `irq_out` bit 0 is the OR of all masked status bits. Bits 1..5 are, in turn, masked receive (bit 4), transmit (bit 5), receive timeout (bit 6), the modem group (bits 3..0) and the error group (bits 10..7). Each output is registered, so it follows a status or mask change one clock edge later.
- R10: Reads of offset 4, of offset 0 and of unmapped offsets 5..7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register word offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_addr` |
| err_evt | input | 4 | Error set pulses {overrun, break, parity, framing} |
| rto_evt | input | 1 | Receive-timeout set pulse |
| rx_count | input | CNT_W | Current receive FIFO fill count |
| rx_trigger | input | CNT_W | Receive FIFO trigger level |
| modem_lines | input | 4 | Modem line flags {DSR, DCD, CTS, RI} |
| irq_out | output | 6 | {error, modem, timeout, transmit, receive, combined} |

## Verification
A status change is due on the same clock edge that captures its cause: a register write, a count change, a modem edge or an event pulse. The bench drives every stimulus at a falling edge and reads the status back at the next falling edge. The interrupt lines trail the status by one more edge. For these lines the bench first confirms that the output still holds its old value half a cycle after the cause, and then checks the new value after a further rising edge. Read data has no latency, so each read is sampled shortly after the address is applied, inside the same low phase.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int ST_W    = 11;
  localparam int NUM_IRQ = 6;

  localparam int B_TX  = 5;
  localparam int B_RX  = 4;
  localparam int B_RTO = 6;
  localparam int B_ERR = 7;   // lowest of the four error bits

  localparam logic [ST_W-1:0] GRP_ERR = 11'h780;
  localparam logic [ST_W-1:0] GRP_MDM = 11'h00F;
  localparam logic [ST_W-1:0] GRP_ALL = 11'h7FF;

  typedef enum logic [2:0] {
    OFS_DATA = 3'd0,
    OFS_MASK = 3'd1,
    OFS_RAW  = 3'd2,
    OFS_MSKD = 3'd3,
    OFS_CLR  = 3'd4
  } reg_ofs_e;

  // Status bits that feed interrupt line idx
  function automatic logic [ST_W-1:0] line_sel(input int idx);
    case (idx)
      0:       return GRP_ALL;
      1:       return ST_W'(1) << B_RX;
      2:       return ST_W'(1) << B_TX;
      3:       return ST_W'(1) << B_RTO;
      4:       return GRP_MDM;
      default: return GRP_ERR;
    endcase
  endfunction

  // Drop the old modem group, then put back each bit whose line is set
  function automatic logic [ST_W-1:0] rebuild_modem(input logic [ST_W-1:0] st,
                                                    input logic [3:0] lines);
    return (st & ~GRP_MDM) | {{(ST_W-4){1'b0}}, lines};
  endfunction

  function automatic logic [ST_W-1:0] event_bits(input logic tx, input logic rx,
                                                 input logic rto, input logic [3:0] err);
    return {err, rto, tx, rx, 4'b0000};
  endfunction

endpackage

// File: rtl/uart_irq_regif.sv
module uart_irq_regif
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ST_W-1:0]   status_q,
  input  logic [ST_W-1:0]   mask_q,
  output logic              data_wr,
  output logic              data_rd,
  output logic              mask_wr,
  output logic              clr_wr,
  output logic [DATA_W-1:0] bus_rdata
);

  logic hit_data, hit_mask, hit_raw, hit_mskd, hit_clr;

  assign hit_data = (bus_addr == ADDR_W'(OFS_DATA));
  assign hit_mask = (bus_addr == ADDR_W'(OFS_MASK));
  assign hit_raw  = (bus_addr == ADDR_W'(OFS_RAW));
  assign hit_mskd = (bus_addr == ADDR_W'(OFS_MSKD));
  assign hit_clr  = (bus_addr == ADDR_W'(OFS_CLR));

  assign data_wr = bus_wr & hit_data;
  assign data_rd = bus_rd & hit_data;
  assign mask_wr = bus_wr & hit_mask;
  assign clr_wr  = bus_wr & hit_clr;

  always_comb begin
    bus_rdata = '0;
    if (hit_mask)      bus_rdata = DATA_W'(mask_q);
    else if (hit_raw)  bus_rdata = DATA_W'(status_q);
    else if (hit_mskd) bus_rdata = DATA_W'(status_q & mask_q);
  end

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_wr,
  input  logic             data_rd,
  input  logic             clr_wr,
  input  logic [ST_W-1:0]  clr_bits,
  input  logic [3:0]       err_evt,
  input  logic             rto_evt,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trigger,
  input  logic [3:0]       modem_lines,
  output logic [ST_W-1:0]  status_q,
  output logic             rx_hit,
  output logic             rx_drain,
  output logic             modem_chg
);

  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       modem_q;
  logic [ST_W-1:0]  status_d;

  assign rx_hit    = (rx_count == rx_trigger) && (rx_count != cnt_q);
  assign rx_drain  = data_rd && (rx_count == rx_trigger);
  assign modem_chg = (modem_lines != modem_q);

  always_comb begin
    status_d = status_q;
    if (clr_wr)    status_d = status_d & ~clr_bits;
    if (modem_chg) status_d = rebuild_modem(status_d, modem_lines);
    if (rx_drain)  status_d[B_RX] = 1'b0;
    status_d = status_d | event_bits(data_wr, rx_hit, rto_evt, err_evt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      cnt_q    <= '0;
      modem_q  <= '0;
    end else begin
      status_q <= status_d;
      cnt_q    <= rx_count;
      modem_q  <= modem_lines;
    end
  end

endmodule

// File: rtl/uart_irq_lines.sv
module uart_irq_lines
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ST_W-1:0]    status_q,
  input  logic [ST_W-1:0]    mask_q,
  output logic [NUM_IRQ-1:0] irq_out
);

  logic [ST_W-1:0] active;
  assign active = status_q & mask_q;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) irq_out[g] <= 1'b0;
      else        irq_out[g] <= |(active & line_sel(g));
    end
  end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [3:0]         err_evt,
  input  logic               rto_evt,
  input  logic [CNT_W-1:0]   rx_count,
  input  logic [CNT_W-1:0]   rx_trigger,
  input  logic [3:0]         modem_lines,
  output logic [NUM_IRQ-1:0] irq_out
);

  logic [ST_W-1:0] status_q;
  logic [ST_W-1:0] mask_q;
  logic            data_wr, data_rd, mask_wr, clr_wr;
  logic            rx_hit, rx_drain, modem_chg;
  logic            unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:ST_W];

  uart_irq_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regif_i (
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .data_wr   (data_wr),
    .data_rd   (data_rd),
    .mask_wr   (mask_wr),
    .clr_wr    (clr_wr),
    .bus_rdata (bus_rdata)
  );

  uart_irq_status #(.CNT_W(CNT_W)) status_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_wr     (data_wr),
    .data_rd     (data_rd),
    .clr_wr      (clr_wr),
    .clr_bits    (bus_wdata[ST_W-1:0]),
    .err_evt     (err_evt),
    .rto_evt     (rto_evt),
    .rx_count    (rx_count),
    .rx_trigger  (rx_trigger),
    .modem_lines (modem_lines),
    .status_q    (status_q),
    .rx_hit      (rx_hit),
    .rx_drain    (rx_drain),
    .modem_chg   (modem_chg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= bus_wdata[ST_W-1:0];
  end

  uart_irq_lines lines_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_q (status_q),
    .mask_q   (mask_q),
    .irq_out  (irq_out)
  );

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_rd,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [3:0]         err_evt,
  input logic [3:0]         modem_lines,
  input logic [NUM_IRQ-1:0] irq_out,
  input logic [ST_W-1:0]    status_q,
  input logic [ST_W-1:0]    mask_q,
  input logic               data_wr,
  input logic               clr_wr,
  input logic               rx_hit,
  input logic               rx_drain,
  input logic               modem_chg
);

  assert_tx_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> status_q[B_TX]);

  assert_rx_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hit |=> status_q[B_RX]);

  assert_rx_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_drain && !rx_hit) |=> !status_q[B_RX]);

  assert_modem_R4: assert property (@(posedge clk) disable iff (!rst_n)
    modem_chg |=> (status_q[3:0] == $past(modem_lines)));

  assert_err_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt[3] |=> status_q[10]);

  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && bus_wdata[B_TX] && !data_wr) |=> !status_q[B_TX]);

  assert_masked_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(OFS_MSKD)) |-> (bus_rdata == DATA_W'(status_q & mask_q)));

  assert_combined_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out[0] == |($past(status_q & mask_q))));

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_rd      (bus_rd),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .err_evt     (err_evt),
  .modem_lines (modem_lines),
  .irq_out     (irq_out),
  .status_q    (status_q),
  .mask_q      (mask_q),
  .data_wr     (data_wr),
  .clr_wr      (clr_wr),
  .rx_hit      (rx_hit),
  .rx_drain    (rx_drain),
  .modem_chg   (modem_chg)
);

// File: tb/uart_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_irq_ctrl_tb_top;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 5;

  localparam logic [2:0] A_DATA = 3'd0, A_MASK = 3'd1, A_RAW = 3'd2,
                         A_MSKD = 3'd3, A_CLR  = 3'd4;

  typedef struct packed {
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic [10:0] raw;
    logic [10:0] msk;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VEC [NVEC] = '{
    '{A_MASK, 32'hFFFF_FFFF, 11'h000, 11'h7FF},
    '{A_DATA, 32'h0000_0041, 11'h020, 11'h7FF},
    '{A_CLR,  32'h0000_0020, 11'h000, 11'h7FF},
    '{A_RAW,  32'h0000_07FF, 11'h000, 11'h7FF},
    '{A_MSKD, 32'h0000_07FF, 11'h000, 11'h7FF},
    '{A_DATA, 32'h0000_0055, 11'h020, 11'h7FF},
    '{A_CLR,  32'h0000_0010, 11'h020, 11'h7FF},
    '{A_MASK, 32'h0000_0010, 11'h020, 11'h010},
    '{A_CLR,  32'hFFFF_FFFF, 11'h000, 11'h010}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic [3:0]        err_evt = '0;
  logic              rto_evt = 1'b0;
  logic [CNT_W-1:0]  rx_count = '0;
  logic [CNT_W-1:0]  rx_trigger = 5'd4;
  logic [3:0]        modem_lines = '0;
  logic [5:0]        irq_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  uart_irq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr (bus_wr),
    .bus_rd (bus_rd), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .err_evt (err_evt), .rto_evt (rto_evt), .rx_count (rx_count),
    .rx_trigger (rx_trigger), .modem_lines (modem_lines), .irq_out (irq_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      bad++; total++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // write in the low phase, completes at the next rising edge
  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 irq during reset", 32'(irq_out), 32'h0);
    rst_n = 1'b1;
    bus_read(A_RAW, rd);  chk("R1 raw after reset", rd, 32'h0);
    bus_read(A_MASK, rd); chk("R1 mask after reset", rd, 32'h0);
    bus_read(A_MSKD, rd); chk("R1 masked after reset", rd, 32'h0);
    chk("R1 irq after reset", 32'(irq_out), 32'h0);

    // table: R2 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      bus_write(VEC[i].addr, VEC[i].wdata);
      bus_read(A_RAW, rd);
      chk($sformatf("R2/R6/R7 raw vec %0d", i), rd, 32'(VEC[i].raw));
      bus_read(A_MASK, rd);
      chk($sformatf("R8 mask vec %0d", i), rd, 32'(VEC[i].msk));
      bus_read(A_MSKD, rd);
      chk($sformatf("R7 masked vec %0d", i), rd, 32'(VEC[i].raw & VEC[i].msk));
    end

    // R10: write-only and unmapped reads
    bus_write(A_DATA, 32'h0);
    bus_read(A_CLR, rd);  chk("R10 clear reg reads zero", rd, 32'h0);
    bus_read(A_DATA, rd); chk("R10 data reg reads zero", rd, 32'h0);
    bus_read(3'd7, rd);   chk("R10 unmapped reads zero", rd, 32'h0);
    bus_write(A_CLR, 32'h7FF);

    // R3: receive trigger level
    rx_count = 5'd3; step;
    bus_read(A_RAW, rd); chk("R3 below trigger", rd, 32'h000);
    @(negedge clk); rx_count = 5'd4; step;
    bus_read(A_RAW, rd); chk("R3 reach trigger", rd, 32'h010);
    bus_read(A_DATA, rd);
    bus_read(A_RAW, rd); chk("R3 read at trigger clears", rd, 32'h000);
    @(negedge clk); rx_count = 5'd3; step;
    @(negedge clk); rx_count = 5'd5; step;
    bus_read(A_RAW, rd); chk("R3 above trigger no set", rd, 32'h000);
    @(negedge clk); rx_count = 5'd4; step;
    bus_read(A_RAW, rd); chk("R3 reach trigger from above", rd, 32'h010);
    @(negedge clk); rx_count = 5'd5; step;
    bus_read(A_DATA, rd);
    bus_read(A_RAW, rd); chk("R3 read off trigger keeps bit", rd, 32'h010);
    bus_write(A_CLR, 32'h7FF);

    // R4: modem rebuild
    @(negedge clk); modem_lines = 4'b1010; step;
    bus_read(A_RAW, rd); chk("R4 DSR and CTS", rd, 32'h00A);
    @(negedge clk); modem_lines = 4'b0001; step;
    bus_read(A_RAW, rd); chk("R4 RI only", rd, 32'h001);
    @(negedge clk); modem_lines = 4'b0000; step;
    bus_read(A_RAW, rd); chk("R4 all lines low", rd, 32'h000);

    // R5: error and timeout pulses
    @(negedge clk); err_evt = 4'b1001;
    @(negedge clk); err_evt = 4'b0000;
    bus_read(A_RAW, rd); chk("R5 overrun and framing", rd, 32'h480);
    @(negedge clk); rto_evt = 1'b1;
    @(negedge clk); rto_evt = 1'b0;
    bus_read(A_RAW, rd); chk("R5 receive timeout", rd, 32'h4C0);

    // R6: set wins over clear in the same cycle
    bus_write(A_CLR, 32'h7FF);
    @(negedge clk);
    bus_addr = A_CLR; bus_wdata = 32'h080; bus_wr = 1'b1; err_evt = 4'b0001;
    @(negedge clk);
    bus_wr = 1'b0; err_evt = 4'b0000;
    bus_read(A_RAW, rd); chk("R6 set beats clear", rd, 32'h080);

    // R9: registered interrupt lines
    chk("R9 masked out before mask write", 32'(irq_out), 32'h00);
    bus_write(A_MASK, 32'h080);
    chk("R9 one edge of latency", 32'(irq_out), 32'h00);
    step;
    chk("R9 error and combined", 32'(irq_out), 32'h21);
    bus_write(A_MASK, 32'h7FF);
    bus_write(A_DATA, 32'h0);
    chk("R9 tx not yet visible", 32'(irq_out), 32'h21);
    step;
    chk("R9 tx error combined", 32'(irq_out), 32'h25);
    @(negedge clk); modem_lines = 4'b0100; rto_evt = 1'b1;
    @(negedge clk); rto_evt = 1'b0;
    step;
    chk("R9 all but rx", 32'(irq_out), 32'h3D);
    bus_write(A_CLR, 32'h7FF);
    step;
    chk("R9 cleared lines", 32'(irq_out), 32'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule